// File: doc/BRIEF.md
# CAN Halt Mode Sequencer

This block steps a CAN controller into and out of a halted condition in which it is detached from the bus. Software raises a halt request bit. The sequencer then waits for a safe point, which is decided by the bus state and two policy bits, and enters the halt on a bit-time tick. On entry it pulses an interrupt and raises a status flag. While the request is pending, new transmit and cancel requests are locked out.

While halted, the participation enable is low, so the controller neither sends nor stores frames. After software clears the request, the sequencer counts consecutive recessive bits on the sampled bus level and re-enables participation after the eleventh. When the policy bits allow it, a transition into bus-off can raise the halt request on its own.

Top module: `can_halt_seq`

## Requirements
- R1: After reset the outputs are: halt_req_o=0, tx_lock_o=0, halted_o=0, halt_irq_o=0, bus_en_o=1.
- R2: A write with req_we_i=1 and req_wd_i=1 sets halt_req_o in the next cycle. From then until halted_o is high, tx_lock_o is high.
- R3: While not bus-off, a pending halt is entered at the first bit_tick_i on which bus_idle_i or bus_intm_i is high and frame_act_i is low, whatever value boff_halt_en_i has. No halt is entered while a frame is in progress or between ticks.
- R4: While bus_off_i is high and boff_halt_en_i is high, a pending halt is entered at the next bit_tick_i.
- R5: While bus_off_i is high and boff_halt_en_i is low, a pending halt is entered only at a bit_tick_i on which boff_rec_done_i is high.
- R6: When auto_halt_i and boff_halt_en_i are both high, a rising edge on bus_off_i sets halt_req_o in the next cycle. If either bit is low, the edge leaves halt_req_o unchanged.
- R7: During the halt and during the rejoin wait, halted_o is 1 and bus_en_o is 0. halted_o changes only on a cycle with bit_tick_i high.
- R8: halt_irq_o is high for exactly one cycle, in the first cycle that halted_o is high.
- R9: A write with req_wd_i=0 is ignored while halted_o is low. While halted_o is high, it clears halt_req_o in the next cycle.
- R10: Once the request is cleared, halted_o falls and bus_en_o rises one cycle after the 11th consecutive bit_tick_i that samples rx_bit_i=1 (recessive). A tick that samples rx_bit_i=0 restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_we_i | input | 1 | Software write strobe for the halt request bit |
| req_wd_i | input | 1 | Value written to the halt request bit |
| boff_halt_en_i | input | 1 | Allows a halt to be taken during bus-off without waiting for recovery |
| auto_halt_i | input | 1 | Raises the request automatically on entry to bus-off |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| bus_idle_i | input | 1 | Bus is idle |
| bus_intm_i | input | 1 | Bus is in intermission |
| frame_act_i | input | 1 | A frame is in progress |
| bus_off_i | input | 1 | Controller is bus-off |
| boff_rec_done_i | input | 1 | Bus-off recovery sequence has completed |
| rx_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| halt_req_o | output | 1 | Current halt request bit |
| halted_o | output | 1 | Halt status flag |
| halt_irq_o | output | 1 | One-cycle pulse on halt entry |
| bus_en_o | output | 1 | Controller may take part in bus traffic |
| tx_lock_o | output | 1 | Blocks new transmit and cancel requests |

## Verification
A sequencer stuck in the pending state shows as tx_lock_o staying high after the tick that should have ended it. An early entry raises halted_o and halt_irq_o one cycle after a tick on which a frame was still active. A miscounting recessive counter moves the rise of bus_en_o away from the 11th recessive tick, and a count that survives a dominant bit makes it rise early. Each of these shows at the ports within one cycle of the deciding tick. A request that can be cleared too soon shows as halt_req_o dropping while halted_o is still low.

// File: rtl/can_halt_pkg.sv
package can_halt_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_PEND   = 2'd1,
    ST_HALT   = 2'd2,
    ST_REJOIN = 2'd3
  } halt_st_e;
endpackage

// File: rtl/can_halt_req.sv
module can_halt_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_val_i,
  input  logic halted_i,
  input  logic auto_i,
  input  logic boff_en_i,
  input  logic bus_off_i,
  output logic req_o
);
  logic bus_off_q;
  logic auto_set;

  assign auto_set = auto_i & boff_en_i & bus_off_i & ~bus_off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_off_q <= 1'b0;
      req_o     <= 1'b0;
    end else begin
      bus_off_q <= bus_off_i;
      if (auto_set || (wr_en_i && wr_val_i)) begin
        req_o <= 1'b1;
      end else if (wr_en_i && !wr_val_i && halted_i) begin
        // clear only honoured once halt is reached
        req_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/can_halt_rcnt.sv
module can_halt_rcnt #(
  parameter int unsigned NBITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic bit_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(NBITS + 1);
  localparam logic [CW-1:0] LAST = CW'(NBITS - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = ~clr_i & tick_i & bit_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (!bit_i)              cnt_q <= '0;
      else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/can_halt_fsm.sv
module can_halt_fsm
  import can_halt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_i,
  input  logic     tick_i,
  input  logic     boff_en_i,
  input  logic     bus_idle_i,
  input  logic     bus_intm_i,
  input  logic     frame_act_i,
  input  logic     bus_off_i,
  input  logic     rec_done_i,
  input  logic     rejoin_done_i,
  output halt_st_e st_o,
  output logic     irq_o
);
  halt_st_e st_q, st_d;
  logic     entry_ok;
  logic     enter;

  // safe point for entry: bus-off policy first, otherwise quiet bus
  assign entry_ok = bus_off_i ? (boff_en_i | rec_done_i)
                              : ((bus_idle_i | bus_intm_i) & ~frame_act_i);
  assign enter    = (st_q == ST_PEND) & tick_i & entry_ok;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:    if (req_i) st_d = ST_PEND;
      ST_PEND:   if (enter) st_d = ST_HALT;
      ST_HALT:   if (!req_i) st_d = ST_REJOIN;
      ST_REJOIN: begin
        if (req_i)              st_d = ST_HALT;
        else if (rejoin_done_i) st_d = ST_RUN;
      end
      default:   st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RUN;
      irq_o <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_o <= enter;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/can_halt_seq.sv
module can_halt_seq
  import can_halt_pkg::*;
#(
  parameter int unsigned REJOIN_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_we_i,
  input  logic req_wd_i,
  input  logic boff_halt_en_i,
  input  logic auto_halt_i,
  input  logic bit_tick_i,
  input  logic bus_idle_i,
  input  logic bus_intm_i,
  input  logic frame_act_i,
  input  logic bus_off_i,
  input  logic boff_rec_done_i,
  input  logic rx_bit_i,
  output logic halt_req_o,
  output logic halted_o,
  output logic halt_irq_o,
  output logic bus_en_o,
  output logic tx_lock_o
);
  halt_st_e st;
  logic     req;
  logic     halted;
  logic     rejoin_done;

  assign halted = (st == ST_HALT) | (st == ST_REJOIN);

  can_halt_req u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (req_we_i),
    .wr_val_i  (req_wd_i),
    .halted_i  (halted),
    .auto_i    (auto_halt_i),
    .boff_en_i (boff_halt_en_i),
    .bus_off_i (bus_off_i),
    .req_o     (req)
  );

  can_halt_rcnt #(.NBITS(REJOIN_BITS)) u_rcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (st != ST_REJOIN),
    .tick_i (bit_tick_i),
    .bit_i  (rx_bit_i),
    .done_o (rejoin_done)
  );

  can_halt_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (req),
    .tick_i        (bit_tick_i),
    .boff_en_i     (boff_halt_en_i),
    .bus_idle_i    (bus_idle_i),
    .bus_intm_i    (bus_intm_i),
    .frame_act_i   (frame_act_i),
    .bus_off_i     (bus_off_i),
    .rec_done_i    (boff_rec_done_i),
    .rejoin_done_i (rejoin_done),
    .st_o          (st),
    .irq_o         (halt_irq_o)
  );

  assign halt_req_o = req;
  assign halted_o   = halted;
  assign bus_en_o   = ~halted;
  assign tx_lock_o  = req & ~halted;
endmodule

// File: rtl/can_halt_chk.sv
module can_halt_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_we_i,
  input logic boff_halt_en_i,
  input logic auto_halt_i,
  input logic bit_tick_i,
  input logic bus_off_i,
  input logic rx_bit_i,
  input logic halt_req_o,
  input logic halted_o,
  input logic halt_irq_o
);
  p_irq_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_irq_o |=> !halt_irq_o);

  p_irq_on_entry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_o) |-> halt_irq_o);

  p_entry_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_o) |-> $past(bit_tick_i));

  p_halt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o && !bit_tick_i |=> halted_o);

  p_req_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_req_o && !halted_o |=> halt_req_o);

  p_rejoin_recessive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halted_o) |-> $past(bit_tick_i) && $past(rx_bit_i));

  p_auto_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_off_i) && auto_halt_i && boff_halt_en_i |=> halt_req_o);

  p_no_spurious_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_req_o && !req_we_i && !bus_off_i |=> !halt_req_o);
endmodule

bind can_halt_seq can_halt_chk u_chk (.*);

// File: tb/can_halt_seq_tb.sv
module can_halt_seq_tb;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_we = 0, req_wd = 0, boff_en = 0, auto_h = 0, tick = 0;
  logic idle = 0, intm = 0, frame = 0, boff = 0, rec_done = 0, rx = 1;
  logic halt_req, halted, irq, bus_en, lock;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  typedef struct {
    string      tag;
    logic [4:0] v;  // {req, lock, halted, irq, bus_en}
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  can_halt_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_we_i(req_we), .req_wd_i(req_wd),
    .boff_halt_en_i(boff_en), .auto_halt_i(auto_h), .bit_tick_i(tick),
    .bus_idle_i(idle), .bus_intm_i(intm), .frame_act_i(frame),
    .bus_off_i(boff), .boff_rec_done_i(rec_done), .rx_bit_i(rx),
    .halt_req_o(halt_req), .halted_o(halted), .halt_irq_o(irq),
    .bus_en_o(bus_en), .tx_lock_o(lock)
  );

  // monitor: pops expectations at the falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      logic [4:0] act;
      e   = exp_q.pop_front();
      act = {halt_req, lock, halted, irq, bus_en};
      n_chk++;
      if (act !== e.v) begin
        n_fail++;
        $display("FAIL %s: {req,lock,halted,irq,bus_en} actual %b expected %b", e.tag, act, e.v);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_out(string tag, logic r, logic l, logic h, logic i, logic b);
    exp_t e;
    e.tag = tag;
    e.v   = {r, l, h, i, b};
    exp_q.push_back(e);
  endtask

  task automatic wr(logic val);
    req_we = 1; req_wd = val;
    step();
    req_we = 0;
  endtask

  task automatic tk(logic bitv);
    rx = bitv; tick = 1;
    step();
    tick = 0;
  endtask

  task automatic rejoin(string tag);
    wr(0);
    expect_out({tag, " R9 clear honoured when halted"}, 0, 0, 1, 0, 0);
    step();
    for (int k = 0; k < 10; k++) tk(1);
    expect_out({tag, " R10 still waiting after 10 recessive"}, 0, 0, 1, 0, 0);
    tk(1);
    expect_out({tag, " R10 rejoin after 11 recessive"}, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (3) step();
    expect_out("R1 reset state", 0, 0, 0, 0, 1);
    step();
    rst_n = 1;
    step();
    expect_out("R1 after release", 0, 0, 0, 0, 1);

    // idle bus halt
    idle = 1;
    wr(1);
    expect_out("R2 request set and lock", 1, 1, 0, 0, 1);
    repeat (3) step();
    expect_out("R3 no entry without tick", 1, 1, 0, 0, 1);
    tk(1);
    expect_out("R3 R8 entry on idle tick", 1, 0, 1, 1, 0);
    step();
    expect_out("R8 R7 irq drops, still halted", 1, 0, 1, 0, 0);

    // rejoin with a dominant restart
    wr(0);
    expect_out("R9 clear when halted", 0, 0, 1, 0, 0);
    step();
    for (int k = 0; k < 5; k++) tk(1);
    tk(0);
    for (int k = 0; k < 10; k++) tk(1);
    expect_out("R10 dominant restarted count", 0, 0, 1, 0, 0);
    tk(1);
    expect_out("R10 rejoined", 0, 0, 0, 0, 1);

    // frame in progress, then intermission
    idle = 0; frame = 1; boff_en = 1;
    wr(1);
    step();
    repeat (3) tk(1);
    expect_out("R3 no entry during frame", 1, 1, 0, 0, 1);
    wr(0);
    expect_out("R9 clear ignored while pending", 1, 1, 0, 0, 1);
    frame = 0; intm = 1;
    tk(1);
    expect_out("R3 entry in intermission", 1, 0, 1, 1, 0);
    intm = 0; idle = 1;
    rejoin("B");

    // bus-off, enable set
    idle = 0; boff = 1; boff_en = 1;
    wr(1);
    step();
    tk(1);
    expect_out("R4 bus-off entry at next tick", 1, 0, 1, 1, 0);
    boff = 0; idle = 1;
    rejoin("C");

    // bus-off, enable clear
    idle = 0; boff = 1; boff_en = 0;
    wr(1);
    step();
    tk(1); tk(1);
    expect_out("R5 waits for recovery", 1, 1, 0, 0, 1);
    rec_done = 1;
    tk(1);
    rec_done = 0;
    expect_out("R5 entry after recovery", 1, 0, 1, 1, 0);
    boff = 0; idle = 1;
    rejoin("D");

    // automatic halt on bus-off
    auto_h = 1; boff_en = 0;
    boff = 1;
    step(); step();
    expect_out("R6 no auto set without enable", 0, 0, 0, 0, 1);
    boff = 0;
    step();
    boff_en = 1; idle = 0;
    boff = 1;
    step();
    expect_out("R6 auto set on bus-off", 1, 1, 0, 0, 1);
    step();
    tk(1);
    expect_out("R6 R4 auto halt entered", 1, 0, 1, 1, 0);
    step();

    @(negedge clk); #1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule